// File: doc/BRIEF.md
# Host Command Receiver and Identity Responder

This block sits between a byte-wide UART receiver/transmitter pair and the control side of a logic-analyzer core. Incoming bytes are framed into host commands. A command whose opcode has bit 7 clear is a single byte. A command whose opcode has bit 7 set is followed by a multi-byte argument, sent most significant byte first. Each completed command is presented to the core as an opcode and argument, qualified by a single-cycle strobe.

Two short commands also start a reply on the transmit side. The identify query returns a fixed four-byte tag. The metadata query returns a self-describing list of key/value entries that ends with a zero key. In that list, the key's upper three bits select the value type: 000 is a zero-terminated ASCII string, 001 is a four-byte integer sent most significant byte first, and 010 is a single-byte integer. Reply bytes leave through a valid/ready handshake. Framing needs no side channel to recover. A run of reset opcodes (0x00) one longer than the argument length always returns the framer to the opcode-expecting state.

Top module: `cmdlink_top`

## Requirements
- R1: An opcode with bit 7 set starts a long command. It is followed by ARG_BYTES (default 4) argument bytes, sent most significant first. In the cycle after the last argument byte is accepted, cmd_valid is high for one clock, with cmd_opcode equal to the opcode and cmd_arg equal to the assembled argument. No strobe is given before the command is complete.
- R2: An opcode byte with bit 7 clear, received while no long command is open, is a short command. In the following cycle cmd_valid is high for one clock, with cmd_opcode equal to that byte and cmd_arg equal to zero.
- R3: From any position inside a long command, five consecutive 0x00 bytes leave the framer expecting an opcode. The last of them is reported as a short command with opcode 0x00, and the next byte is treated as an opcode.
- R4: Short opcode 0x02 starts a reply of exactly four bytes: 0x31, 0x53, 0x4C, 0x4F, in that order.
- R5: Short opcode 0x04 starts the metadata reply. By default it is these 22 bytes: 0x01 'L' 'A' 0x00 (the device name string); 0x20 followed by the four-byte probe count 32; 0x21 followed by the four-byte sample memory size in bytes, 24576; 0x23 followed by the four-byte maximum sample rate in Hz, 200000000; 0x41 followed by the one-byte protocol version 2; and finally the end key 0x00.
- R6: A reply byte is consumed only in a cycle where tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R7: A reply request that arrives while a reply is in progress is dropped. A request made after the last reply byte has been accepted starts a new reply.
- R8: After reset, cmd_valid and tx_valid are low, and the framer expects an opcode.
- R9: A byte on rx_data is taken only in a cycle where rx_valid is high. Data present while rx_valid is low has no effect on commands or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| tx_data | output | 8 | Reply byte to the UART transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| cmd_valid | output | 1 | One-clock strobe for a completed command |
| cmd_opcode | output | 8 | Opcode of the completed command |
| cmd_arg | output | 8*ARG_BYTES | Argument of the completed command; zero for short commands |

## Verification
The framer's argument counter is not visible at the ports, so a fault in it shows up only indirectly. A miscounted argument shows as a command strobe one byte early or late, or as a shifted cmd_arg, on the very next long command. It also shows as a following short opcode that is swallowed as an argument, which the resynchronisation runs expose at every partial depth. A wrong reply index or a lost hold appears within the reply as a misordered, repeated or missing transmit byte. Checking runs with random backpressure compares the byte stream, so these faults are caught there. A broken busy flag shows as an extra or truncated reply when a second query lands during a stalled reply.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_ARGS = 1'b1
   } fr_state_e;

   typedef enum logic {
      RP_IDENT = 1'b0,
      RP_META  = 1'b1
   } rp_kind_e;

   localparam int unsigned IDENT_LEN = 4;

   // metadata key codes; upper three bits select the value type
   localparam logic [7:0] KEY_END    = 8'h00;
   localparam logic [7:0] KEY_NAME   = 8'h01;
   localparam logic [7:0] KEY_PROBES = 8'h20;
   localparam logic [7:0] KEY_MEM    = 8'h21;
   localparam logic [7:0] KEY_RATE   = 8'h23;
   localparam logic [7:0] KEY_PROTO  = 8'h41;

   function automatic logic [7:0] ident_byte(input logic [1:0] pos);
      case (pos)
         2'd0:    return 8'h31;
         2'd1:    return 8'h53;
         2'd2:    return 8'h4C;
         default: return 8'h4F;
      endcase
   endfunction

   function automatic int unsigned meta_length(input int unsigned name_chars);
      return name_chars + 20;
   endfunction

endpackage

// File: rtl/cmdlink_framer.sv
module cmdlink_framer
   import cmdlink_pkg::*;
#(
   parameter int unsigned ARG_BYTES = 4,
   parameter int unsigned LONG_BIT  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               rx_data,
   input  logic                     rx_valid,
   output logic                     cmd_valid,
   output logic [7:0]               cmd_opcode,
   output logic [8*ARG_BYTES-1:0]   cmd_arg
);

   localparam int unsigned ARG_W = 8 * ARG_BYTES;
   localparam int unsigned CNT_W = $clog2(ARG_BYTES + 1);

   fr_state_e          state_q;
   logic [CNT_W-1:0]   left_q;
   logic [7:0]         op_q;
   logic [7:0]         slot_q [ARG_BYTES];
   logic [ARG_W-1:0]   arg_now;
   logic               take_op;
   logic               take_arg;
   logic               last_arg;
   logic               cmd_valid_q;
   logic [7:0]         cmd_op_q;
   logic [ARG_W-1:0]   cmd_arg_q;

   assign take_op  = rx_valid && (state_q == FR_IDLE);
   assign take_arg = rx_valid && (state_q == FR_ARGS);
   assign last_arg = take_arg && (left_q == CNT_W'(1));

   // slot k holds argument byte k (0 = least significant); first byte on the wire is the top slot
   generate
      for (genvar k = 0; k < ARG_BYTES; k++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[k] <= '0;
            end else if (take_arg && (left_q == CNT_W'(k + 1))) begin
               slot_q[k] <= rx_data;
            end
         end
         if (k == 0) begin : g_lsb
            assign arg_now[7:0] = rx_data;
         end else begin : g_upper
            assign arg_now[8*k +: 8] = slot_q[k];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= FR_IDLE;
         left_q      <= '0;
         op_q        <= '0;
         cmd_valid_q <= 1'b0;
         cmd_op_q    <= '0;
         cmd_arg_q   <= '0;
      end else begin
         cmd_valid_q <= 1'b0;
         if (take_op) begin
            if (rx_data[LONG_BIT]) begin
               state_q <= FR_ARGS;
               left_q  <= CNT_W'(ARG_BYTES);
               op_q    <= rx_data;
            end else begin
               cmd_valid_q <= 1'b1;
               cmd_op_q    <= rx_data;
               cmd_arg_q   <= '0;
            end
         end else if (take_arg) begin
            left_q <= left_q - CNT_W'(1);
            if (last_arg) begin
               state_q     <= FR_IDLE;
               cmd_valid_q <= 1'b1;
               cmd_op_q    <= op_q;
               cmd_arg_q   <= arg_now;
            end
         end
      end
   end

   assign cmd_valid  = cmd_valid_q;
   assign cmd_opcode = cmd_op_q;
   assign cmd_arg    = cmd_arg_q;

endmodule

// File: rtl/cmdlink_meta_rom.sv
module cmdlink_meta_rom
   import cmdlink_pkg::*;
#(
   parameter int unsigned                  NAME_CHARS = 2,
   parameter logic [8*NAME_CHARS-1:0]      NAME_TXT   = "LA",
   parameter logic [31:0]                  PROBES     = 32'd32,
   parameter logic [31:0]                  MEM_BYTES  = 32'd24576,
   parameter logic [31:0]                  MAX_RATE   = 32'd200000000,
   parameter logic [7:0]                   PROTO_VER  = 8'd2,
   parameter int unsigned                  IDX_W      = 5
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);

   localparam int unsigned BASE = NAME_CHARS + 2;

   int unsigned pos;
   int unsigned rel;

   always_comb begin
      pos    = 32'(idx);
      rel    = 0;
      byte_o = KEY_END;
      if (pos == 0) begin
         byte_o = KEY_NAME;
      end else if (pos <= NAME_CHARS) begin
         byte_o = NAME_TXT[8*(NAME_CHARS - pos) +: 8];
      end else if (pos == NAME_CHARS + 1) begin
         byte_o = 8'h00;
      end else begin
         rel = pos - BASE;
         case (rel)
            0:  byte_o = KEY_PROBES;
            1:  byte_o = PROBES[31:24];
            2:  byte_o = PROBES[23:16];
            3:  byte_o = PROBES[15:8];
            4:  byte_o = PROBES[7:0];
            5:  byte_o = KEY_MEM;
            6:  byte_o = MEM_BYTES[31:24];
            7:  byte_o = MEM_BYTES[23:16];
            8:  byte_o = MEM_BYTES[15:8];
            9:  byte_o = MEM_BYTES[7:0];
            10: byte_o = KEY_RATE;
            11: byte_o = MAX_RATE[31:24];
            12: byte_o = MAX_RATE[23:16];
            13: byte_o = MAX_RATE[15:8];
            14: byte_o = MAX_RATE[7:0];
            15: byte_o = KEY_PROTO;
            16: byte_o = PROTO_VER;
            default: byte_o = KEY_END;
         endcase
      end
   end

endmodule

// File: rtl/cmdlink_replier.sv
module cmdlink_replier
   import cmdlink_pkg::*;
#(
   parameter int unsigned META_LEN = 22,
   parameter int unsigned IDX_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_ident,
   input  logic             req_meta,
   input  logic [7:0]       meta_byte,
   output logic [IDX_W-1:0] meta_idx,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   input  logic             tx_ready
);

   logic             busy_q;
   rp_kind_e         kind_q;
   logic [IDX_W-1:0] idx_q;
   logic             at_last;

   assign at_last = (kind_q == RP_IDENT) ? (idx_q == IDX_W'(IDENT_LEN - 1))
                                         : (idx_q == IDX_W'(META_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= RP_IDENT;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (req_ident || req_meta) begin
            busy_q <= 1'b1;
            kind_q <= req_meta ? RP_META : RP_IDENT;
            idx_q  <= '0;
         end
      end else if (tx_ready) begin
         if (at_last) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   assign meta_idx = idx_q;
   assign tx_valid = busy_q;
   assign tx_data  = (kind_q == RP_IDENT) ? ident_byte(idx_q[1:0]) : meta_byte;

endmodule

// File: rtl/cmdlink_top.sv
module cmdlink_top
   import cmdlink_pkg::*;
#(
   parameter int unsigned             ARG_BYTES  = 4,
   parameter int unsigned             LONG_BIT   = 7,
   parameter logic [7:0]              IDENT_OP   = 8'h02,
   parameter logic [7:0]              META_OP    = 8'h04,
   parameter int unsigned             NAME_CHARS = 2,
   parameter logic [8*NAME_CHARS-1:0] NAME_TXT   = "LA",
   parameter logic [31:0]             PROBES     = 32'd32,
   parameter logic [31:0]             MEM_BYTES  = 32'd24576,
   parameter logic [31:0]             MAX_RATE   = 32'd200000000,
   parameter logic [7:0]              PROTO_VER  = 8'd2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              rx_data,
   input  logic                    rx_valid,
   output logic [7:0]              tx_data,
   output logic                    tx_valid,
   input  logic                    tx_ready,
   output logic                    cmd_valid,
   output logic [7:0]              cmd_opcode,
   output logic [8*ARG_BYTES-1:0]  cmd_arg
);

   localparam int unsigned META_LEN = meta_length(NAME_CHARS);
   localparam int unsigned IDX_W    = $clog2(META_LEN);

   generate
      if (ARG_BYTES < 1) begin : g_bad_args
         $error("ARG_BYTES must be at least 1");
      end
      if (LONG_BIT > 7) begin : g_bad_flag
         $error("LONG_BIT must index a bit of a byte");
      end
      if (IDENT_OP[LONG_BIT] || META_OP[LONG_BIT]) begin : g_bad_query
         $error("query opcodes must be short commands");
      end
      if (IDENT_OP == META_OP) begin : g_same_query
         $error("query opcodes must differ");
      end
      if (NAME_CHARS < 1) begin : g_bad_name
         $error("NAME_CHARS must be at least 1");
      end
   endgenerate

   logic             req_ident;
   logic             req_meta;
   logic [IDX_W-1:0] meta_idx;
   logic [7:0]       meta_byte;

   cmdlink_framer #(
      .ARG_BYTES (ARG_BYTES),
      .LONG_BIT  (LONG_BIT)
   ) framer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .cmd_valid  (cmd_valid),
      .cmd_opcode (cmd_opcode),
      .cmd_arg    (cmd_arg)
   );

   assign req_ident = cmd_valid && (cmd_opcode == IDENT_OP);
   assign req_meta  = cmd_valid && (cmd_opcode == META_OP);

   cmdlink_meta_rom #(
      .NAME_CHARS (NAME_CHARS),
      .NAME_TXT   (NAME_TXT),
      .PROBES     (PROBES),
      .MEM_BYTES  (MEM_BYTES),
      .MAX_RATE   (MAX_RATE),
      .PROTO_VER  (PROTO_VER),
      .IDX_W      (IDX_W)
   ) rom_i (
      .idx    (meta_idx),
      .byte_o (meta_byte)
   );

   cmdlink_replier #(
      .META_LEN (META_LEN),
      .IDX_W    (IDX_W)
   ) replier_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_ident (req_ident),
      .req_meta  (req_meta),
      .meta_byte (meta_byte),
      .meta_idx  (meta_idx),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready)
   );

endmodule

// File: rtl/cmdlink_checker.sv
module cmdlink_checker #(
   parameter int unsigned ARG_BYTES = 4,
   parameter int unsigned LONG_BIT  = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rx_valid,
   input logic [7:0]             tx_data,
   input logic                   tx_valid,
   input logic                   tx_ready,
   input logic                   cmd_valid,
   input logic [7:0]             cmd_opcode,
   input logic [8*ARG_BYTES-1:0] cmd_arg
);

   // R6: a stalled reply byte is held unchanged
   assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R2: short commands carry a zero argument
   assert_short_arg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_opcode[LONG_BIT]) |-> (cmd_arg == '0));

   // R1: a command strobe always follows an accepted byte
   assert_cmd_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(rx_valid));

   // R4: a reply only begins right after a command strobe
   assert_reply_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> $past(cmd_valid));

   // R7: a reply ends only on an accepted byte
   assert_reply_end_accepted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_valid) |-> $past(tx_ready));

endmodule

bind cmdlink_top cmdlink_checker #(
   .ARG_BYTES (ARG_BYTES),
   .LONG_BIT  (LONG_BIT)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .tx_data    (tx_data),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .cmd_valid  (cmd_valid),
   .cmd_opcode (cmd_opcode),
   .cmd_arg    (cmd_arg)
);

// File: tb/cmdlink_top_tb_top.sv
`timescale 1ns/1ps
module cmdlink_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_valid = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic        cmd_valid;
   logic [7:0]  cmd_opcode;
   logic [31:0] cmd_arg;

   always #2 clk = ~clk;

   cmdlink_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .tx_data    (tx_data),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .cmd_valid  (cmd_valid),
      .cmd_opcode (cmd_opcode),
      .cmd_arg    (cmd_arg)
   );

   int          checks = 0;
   int          failures = 0;
   bit          finished = 1'b0;
   int          stall_mode = 0;
   logic [7:0]  lfsr = 8'hA5;
   logic [7:0]  tx_log [64];
   int          tx_cnt = 0;
   logic [7:0]  op_log [64];
   logic [31:0] arg_log [64];
   int          cmd_cnt = 0;
   logic [7:0]  meta_exp [22];

   // drives tx_ready and records handshakes that the next edge will complete
   always @(negedge clk) begin
      case (stall_mode)
         0: tx_ready = 1'b1;
         1: begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_ready = lfsr[0];
         end
         default: tx_ready = 1'b0;
      endcase
      if (rst_n && tx_valid && tx_ready) begin
         tx_log[tx_cnt % 64] = tx_data;
         tx_cnt = tx_cnt + 1;
      end
      if (rst_n && cmd_valid) begin
         op_log[cmd_cnt % 64]  = cmd_opcode;
         arg_log[cmd_cnt % 64] = cmd_arg;
         cmd_cnt = cmd_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_data  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_data  = 8'h00;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_logs();
      settle(1);
      tx_cnt  = 0;
      cmd_cnt = 0;
   endtask

   task automatic build_meta();
      logic [7:0] v [22] = '{8'h01, 8'h4C, 8'h41, 8'h00,
                             8'h20, 8'h00, 8'h00, 8'h00, 8'h20,
                             8'h21, 8'h00, 8'h00, 8'h60, 8'h00,
                             8'h23, 8'h0B, 8'hEB, 8'hC2, 8'h00,
                             8'h41, 8'h02, 8'h00};
      for (int i = 0; i < 22; i++) meta_exp[i] = v[i];
   endtask

   task automatic test_reset_state();
      chk("R8 cmd_valid after reset", 32'(cmd_valid), 32'd0);
      chk("R8 tx_valid after reset", 32'(tx_valid), 32'd0);
   endtask

   task automatic test_long();
      clear_logs();
      send_byte(8'h81);
      send_byte(8'h12);
      send_byte(8'h34);
      send_byte(8'h56);
      chk("R1 no strobe before last byte", 32'(cmd_cnt), 32'd0);
      send_byte(8'h78);
      settle(2);
      chk("R1 long strobe count", 32'(cmd_cnt), 32'd1);
      chk("R1 long opcode", 32'(op_log[0]), 32'h81);
      chk("R1 long argument", arg_log[0], 32'h12345678);
      clear_logs();
      send_byte(8'hC3);
      send_byte(8'hFF);
      send_byte(8'h00);
      send_byte(8'h01);
      send_byte(8'h80);
      settle(2);
      chk("R1 second long opcode", 32'(op_log[0]), 32'hC3);
      chk("R1 second long argument", arg_log[0], 32'hFF000180);
   endtask

   task automatic test_short();
      clear_logs();
      send_byte(8'h11);
      send_byte(8'h7F);
      settle(2);
      chk("R2 short count", 32'(cmd_cnt), 32'd2);
      chk("R2 short opcode a", 32'(op_log[0]), 32'h11);
      chk("R2 short arg a", arg_log[0], 32'h0);
      chk("R2 short opcode b", 32'(op_log[1]), 32'h7F);
      chk("R2 short arg b", arg_log[1], 32'h0);
   endtask

   task automatic test_rx_gate();
      clear_logs();
      @(negedge clk);
      rx_data = 8'h85;
      settle(4);
      rx_data = 8'h00;
      chk("R9 no strobe without rx_valid", 32'(cmd_cnt), 32'd0);
      send_byte(8'h22);
      settle(2);
      chk("R9 framer still idle", 32'(op_log[0]), 32'h22);
      chk("R9 following short count", 32'(cmd_cnt), 32'd1);
   endtask

   task automatic test_resync();
      for (int d = 1; d <= 4; d++) begin
         clear_logs();
         send_byte(8'h9A);
         for (int j = 1; j < d; j++) send_byte(8'hEE);
         for (int z = 0; z < 5; z++) send_byte(8'h00);
         send_byte(8'h33);
         settle(2);
         chk($sformatf("R3 depth %0d marker opcode", d), 32'(op_log[(cmd_cnt - 1) % 64]), 32'h33);
         chk($sformatf("R3 depth %0d marker arg", d), arg_log[(cmd_cnt - 1) % 64], 32'h0);
         chk($sformatf("R3 depth %0d reset opcode", d), 32'(op_log[(cmd_cnt - 2) % 64]), 32'h00);
      end
   endtask

   task automatic test_ident();
      logic [7:0] id [4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
      stall_mode = 0;
      clear_logs();
      send_byte(8'h02);
      settle(20);
      chk("R4 identify length", 32'(tx_cnt), 32'd4);
      for (int i = 0; i < 4; i++)
         chk($sformatf("R4 identify byte %0d", i), 32'(tx_log[i]), 32'(id[i]));
      chk("R2 identify strobe", 32'(op_log[0]), 32'h02);
   endtask

   task automatic test_meta();
      stall_mode = 1;
      clear_logs();
      send_byte(8'h04);
      settle(200);
      chk("R5 metadata length", 32'(tx_cnt), 32'd22);
      for (int i = 0; i < 22; i++)
         chk($sformatf("R5 R6 metadata byte %0d", i), 32'(tx_log[i]), 32'(meta_exp[i]));
      stall_mode = 0;
      settle(2);
   endtask

   task automatic test_holdoff();
      stall_mode = 2;
      clear_logs();
      send_byte(8'h02);
      send_byte(8'h04);
      settle(3);
      chk("R6 valid held under stall", 32'(tx_valid), 32'd1);
      chk("R6 data held under stall", 32'(tx_data), 32'h31);
      settle(5);
      chk("R6 data still held", 32'(tx_data), 32'h31);
      chk("R6 nothing consumed", 32'(tx_cnt), 32'd0);
      stall_mode = 0;
      settle(20);
      chk("R7 second request dropped", 32'(tx_cnt), 32'd4);
      chk("R7 last byte of kept reply", 32'(tx_log[3]), 32'h4F);
      clear_logs();
      send_byte(8'h04);
      settle(40);
      chk("R7 request after completion served", 32'(tx_cnt), 32'd22);
      chk("R7 new reply first byte", 32'(tx_log[0]), 32'h01);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks   = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      build_meta();
      stall_mode = 0;
      settle(4);
      rst_n = 1'b1;
      settle(2);
      test_reset_state();
      test_long();
      test_short();
      test_rx_gate();
      test_resync();
      test_ident();
      test_meta();
      test_holdoff();
      settle(4);
      finish_run();
   end

endmodule